// File: doc/BRIEF.md
# Signed Halfword Dual Multiply-Accumulate Unit

This block is a 64-bit signed multiply-accumulate datapath for a processor execute stage. Each cycle it may accept two 32-bit operand words, a 64-bit running total delivered as separate low and high words, and a 3-bit operation code. It forms a product term and adds it to the running total. The product term can be a 32x32 signed product, one signed 16x16 product of halfwords chosen independently from each operand, or the sum of two 16x16 products. The two products can pair like halves or opposite halves.

The sum is captured in a result register on the clock edge that follows an accepted input. A strobe marks the cycle in which the new result is present. The caller writes the low and high result words back to wherever the running total is kept. The unit has no flags, status or saturation. Every sum wraps at 64 bits.

Top module: `dual_half_mac`

## Requirements
- R1: With op code 000, both operand words are two's complement signed 32-bit values. Their 64-bit product is added to the 64-bit accumulator {acc_hi, acc_lo}.
- R2: Op codes 001, 010, 011 and 100 form one signed 16x16 product. Op 001 uses the first operand's bits [15:0] and the second operand's bits [15:0]. Op 010 uses the first operand's bits [15:0] and the second operand's bits [31:16]. Op 011 uses the first operand's bits [31:16] and the second operand's bits [15:0]. Op 100 uses bits [31:16] of both operands.
- R3: Any halfword that the op code does not select has no effect on the result.
- R4: A single-halfword product is a signed 32-bit value. It is sign-extended to 64 bits before it is added to the accumulator.
- R5: Op code 101 adds two products to the accumulator: the product of the two [31:16] halves and the product of the two [15:0] halves.
- R6: Op code 110 adds two products to the accumulator: first operand [31:16] times second operand [15:0], and first operand [15:0] times second operand [31:16].
- R7: The addition wraps modulo 2^64. There is no saturation and no overflow indication.
- R8: Op code 111 is reserved. It returns the accumulator unchanged.
- R9: out_valid is high exactly one clock after a cycle with in_valid high, and low after a cycle with in_valid low. The result words change only on a cycle that follows an accepted input.
- R10: While rst_n is low, out_valid is low.
- R11: In the dual modes, each product is sign-extended to 64 bits before the two are summed. When all four halfwords are -32768, the accumulator grows by exactly 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Inputs on this cycle are accepted |
| op_sel | input | 3 | Operation code (see R1, R2, R5, R6, R8) |
| opnd_a | input | 32 | First operand word |
| opnd_b | input | 32 | Second operand word |
| acc_lo | input | 32 | Accumulator bits [31:0] |
| acc_hi | input | 32 | Accumulator bits [63:32] |
| out_valid | output | 1 | Result registered from the previous accepted input |
| res_lo | output | 32 | Result bits [31:0] |
| res_hi | output | 32 | Result bits [63:32] |

## Verification
The assertions take for granted that op_sel and the operand words are driven with known values whenever in_valid is high. The sign-range and reserved-code properties sample those inputs in the same cycle, so they depend on this. The bench changes inputs only on the falling edge and holds them across the rising edge. It sweeps every op code over corner and pseudo-random operand words, so only settled values are sampled. Idle cycles carry junk operands with in_valid low, so that the hold property is tested against real input changes.

// File: rtl/dhmac_pkg.sv
package dhmac_pkg;

  typedef enum logic [2:0] {
    OP_WORD = 3'b000,
    OP_BB   = 3'b001,
    OP_BT   = 3'b010,
    OP_TB   = 3'b011,
    OP_TT   = 3'b100,
    OP_DSTR = 3'b101,
    OP_DCRS = 3'b110,
    OP_PASS = 3'b111
  } op_e;

  function automatic logic op_is_single(input op_e op);
    return (op == OP_BB) || (op == OP_BT) || (op == OP_TB) || (op == OP_TT);
  endfunction

  function automatic logic op_is_dual(input op_e op);
    return (op == OP_DSTR) || (op == OP_DCRS);
  endfunction

endpackage

// File: rtl/dhmac_lane_sel.sv
module dhmac_lane_sel
  import dhmac_pkg::*;
#(
  parameter int LANE = 0
) (
  input  op_e  op,
  output logic a_top,
  output logic b_top,
  output logic en
);

  generate
    if (LANE == 0) begin : g_lane0
      always_comb begin
        a_top = 1'b0;
        b_top = 1'b0;
        en    = 1'b0;
        unique case (op)
          OP_BB:   begin en = 1'b1; end
          OP_BT:   begin en = 1'b1; b_top = 1'b1; end
          OP_TB:   begin en = 1'b1; a_top = 1'b1; end
          OP_TT:   begin en = 1'b1; a_top = 1'b1; b_top = 1'b1; end
          OP_DSTR: begin en = 1'b1; end
          OP_DCRS: begin en = 1'b1; b_top = 1'b1; end
          default: begin en = 1'b0; end
        endcase
      end
    end else begin : g_lane1
      always_comb begin
        a_top = 1'b1;
        b_top = (op == OP_DSTR);
        en    = op_is_dual(op);
      end
    end
  endgenerate

endmodule

// File: rtl/dhmac_smul.sv
module dhmac_smul #(
  parameter int AW = 16,
  parameter int BW = 16,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [PW-1:0] p
);

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  always_comb begin
    a_ext = $signed({{BW{a[AW-1]}}, a});
    b_ext = $signed({{AW{b[BW-1]}}, b});
    p     = a_ext * b_ext;
  end

endmodule

// File: rtl/dhmac_accum.sv
module dhmac_accum
  import dhmac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 2,
  localparam int ACC_W = 2 * WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  op_e                           op,
  input  logic [ACC_W-1:0]              full_prod,
  input  logic [LANES-1:0][WORD_W-1:0]  lane_prod,
  input  logic [LANES-1:0]              lane_en,
  input  logic [ACC_W-1:0]              acc_in,
  output logic                          out_valid,
  output logic [ACC_W-1:0]              result
);

  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] sum_nxt;
  logic [ACC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  always_comb begin
    addend = '0;
    if (op == OP_WORD) begin
      addend = full_prod;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_en[i]) begin
          addend = addend + {{WORD_W{lane_prod[i][WORD_W-1]}}, lane_prod[i]};
        end
      end
    end
    sum_nxt = acc_in + addend;
  end

  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? sum_nxt : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  p_single_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_single(op)) |->
      ((addend[ACC_W-1:WORD_W-1] == '0) || (addend[ACC_W-1:WORD_W-1] == '1)));

  p_dual_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_dual(op)) |->
      ((addend[ACC_W-1:WORD_W] == '0) || (addend[ACC_W-1:WORD_W] == '1)));

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PASS) |=> (result == $past(acc_in)));

endmodule

// File: rtl/dual_half_mac.sv
module dual_half_mac
  import dhmac_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] acc_lo,
  input  logic [WORD_W-1:0] acc_hi,
  output logic              out_valid,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi
);

  op_e                         op;
  logic [ACC_W-1:0]            full_prod;
  logic [LANES-1:0][WORD_W-1:0] lane_prod;
  logic [LANES-1:0]            lane_en;
  logic [ACC_W-1:0]            result;

  assign op = op_e'(op_sel);

  dhmac_smul #(.AW(WORD_W), .BW(WORD_W)) u_full_mul (
    .a (opnd_a),
    .b (opnd_b),
    .p (full_prod)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              a_top, b_top;
    logic [HALF_W-1:0] a_half, b_half;

    dhmac_lane_sel #(.LANE(g)) u_sel (
      .op    (op),
      .a_top (a_top),
      .b_top (b_top),
      .en    (lane_en[g])
    );

    assign a_half = a_top ? opnd_a[WORD_W-1:HALF_W] : opnd_a[HALF_W-1:0];
    assign b_half = b_top ? opnd_b[WORD_W-1:HALF_W] : opnd_b[HALF_W-1:0];

    dhmac_smul #(.AW(HALF_W), .BW(HALF_W)) u_half_mul (
      .a (a_half),
      .b (b_half),
      .p (lane_prod[g])
    );
  end

  dhmac_accum #(.WORD_W(WORD_W), .LANES(LANES)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .full_prod (full_prod),
    .lane_prod (lane_prod),
    .lane_en   (lane_en),
    .acc_in    ({acc_hi, acc_lo}),
    .out_valid (out_valid),
    .result    (result)
  );

  assign res_lo = result[WORD_W-1:0];
  assign res_hi = result[ACC_W-1:WORD_W];

  // R3: the second lane must stay idle unless a dual op is selected
  p_lane1_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_is_dual(op)) |-> !lane_en[1]);

  // R2: a single-halfword op always has the first lane active
  p_lane0_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_single(op)) |-> lane_en[0]);

endmodule

// File: tb/dual_half_mac_bench.sv
module dual_half_mac_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [31:0] opnd_a, opnd_b, acc_lo, acc_hi;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  dual_half_mac u_dual_half_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [63:0] acc);
    longint al, ah, bl, bh, aw, bw;
    al = longint'($signed(a[15:0]));  ah = longint'($signed(a[31:16]));
    bl = longint'($signed(b[15:0]));  bh = longint'($signed(b[31:16]));
    aw = longint'($signed(a));        bw = longint'($signed(b));
    case (op)
      3'd0: return acc + 64'(aw * bw);
      3'd1: return acc + 64'(al * bl);
      3'd2: return acc + 64'(al * bh);
      3'd3: return acc + 64'(ah * bl);
      3'd4: return acc + 64'(ah * bh);
      3'd5: return acc + 64'(al * bl + ah * bh);
      3'd6: return acc + 64'(al * bh + ah * bl);
      default: return acc;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd5: return "R5";
      3'd6: return "R6";
      3'd7: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    {acc_hi, acc_lo} = acc;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " strobe"}, {63'd0, out_valid}, 64'd1);
    check(tag, {res_hi, res_lo}, exp);
  endtask

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                               32'h7FFF_FFFF, 32'h8000_8000, 32'h7FFF_8000, 32'h0001_FFFF};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] acc, last;
    logic [31:0] a, b, ja, jb, ma, mb;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0;
    opnd_a = '0; opnd_b = '0; acc_lo = '0; acc_hi = '0;
    repeat (3) @(negedge clk);
    check("R10 reset strobe", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle strobe", {63'd0, out_valid}, 64'd0);

    // corner sweep: every op over all corner operand pairs
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          acc = next_rand();
          run_op(op_tag(3'(op)), 3'(op), corners[i], corners[j], acc,
                 model(3'(op), corners[i], corners[j], acc));
        end

    // pseudo-random sweep
    for (int n = 0; n < 400; n++) begin
      a = next_rand(); b = next_rand(); acc = next_rand();
      run_op(op_tag(3'(n % 8)), 3'(n % 8), a, b, acc, model(3'(n % 8), a, b, acc));
    end

    // R3: junk in the unselected halves of single ops
    for (int n = 0; n < 64; n++) begin
      logic [2:0] op;
      op = 3'(1 + (n % 4));
      a = next_rand(); b = next_rand(); acc = next_rand();
      ja = next_rand(); jb = next_rand();
      ma = (op == 3'd3 || op == 3'd4) ? 32'hFFFF_0000 : 32'h0000_FFFF;
      mb = (op == 3'd2 || op == 3'd4) ? 32'hFFFF_0000 : 32'h0000_FFFF;
      run_op("R3", op, (a & ma) | (ja & ~ma), (b & mb) | (jb & ~mb), acc,
             model(op, a & ma, b & mb, acc));
    end

    // R4: negative single product extends through the upper word
    run_op("R4", 3'd1, 32'h0000_FFFF, 32'h0000_0001, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R4", 3'd4, 32'h8000_0000, 32'h7FFF_0000, 64'd5, 64'hFFFF_FFFF_C000_8005);

    // R7: wrap modulo 2^64
    run_op("R7", 3'd0, 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    run_op("R7", 3'd1, 32'd1, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);

    // R11: both dual products at +2^30
    run_op("R11", 3'd5, 32'h8000_8000, 32'h8000_8000, 64'd0, 64'h0000_0000_8000_0000);
    run_op("R11", 3'd6, 32'h8000_8000, 32'h8000_8000, 64'd3, 64'h0000_0000_8000_0003);

    // R9: idle cycles with junk inputs leave result and strobe alone
    run_op("R9", 3'd0, 32'd6, 32'd7, 64'd100, 64'd142);
    last = 64'd142;
    for (int n = 0; n < 4; n++) begin
      opnd_a = next_rand(); opnd_b = next_rand(); {acc_hi, acc_lo} = next_rand();
      op_sel = 3'(n);
      @(negedge clk);
      check("R9 idle strobe", {63'd0, out_valid}, 64'd0);
      check("R9 hold", {res_hi, res_lo}, last);
    end

    // R10: reset mid-stream
    @(negedge clk);
    in_valid = 1'b1; op_sel = 3'd0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async strobe", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 held strobe", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    run_op("R1", 3'd0, 32'hFFFF_FFFE, 32'd3, 64'd10, 64'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule